// File: doc/BRIEF.md
# AXI ID Filtered Event Generator

This block watches three AXI channels: read address, write address and read data. It turns each handshake whose transaction ID passes a programmable filter into a single-cycle event pulse. There are three pulses: filtered read transactions, filtered write transactions and filtered read data beats. A separate counter bank counts these pulses. In that bank, each pulse is the same event code (73) on a different counter: counter 2 for reads, counter 3 for writes and counter 4 for read beats.

The three filters share one ID/mask pair, and each filter has its own enable. An ID passes when it agrees with the programmed ID in every bit that the mask selects, so an all-zero mask lets every ID through. Software programs the filter through a small register port that holds two 32-bit words. Each pulse is registered, so it appears in the cycle after the handshake that caused it. A register write takes effect for handshakes from the next clock edge onwards.

Top module: `idf_event_gen`

## Requirements
- R1: After reset, both configuration words read as zero and all three event outputs are low.
- R2: The control word at byte offset 0x0 holds the read-transaction enable in bit 31, the write-transaction enable in bit 30, the read-beat enable in bit 29 and the 18-bit ID mask in bits 17:0. A written value reads back in those bits.
- R3: The ID word at byte offset 0x4 holds the 18-bit reference ID in bits 17:0. A written value reads back in those bits.
- R4: Bits outside the defined fields read as zero, and writes to them are ignored. The unmapped offset 0x8 reads as zero, and a write to it changes neither word.
- R5: A channel ID matches when (ID AND mask) equals (reference ID AND mask). With a zero mask, every ID matches.
- R6: `evt_rd_txn` is high for exactly one cycle in the cycle after each read-address handshake (valid and ready both high) whose ID matches while the read-transaction enable is set. Back-to-back handshakes give back-to-back pulses.
- R7: `evt_wr_txn` behaves in the same way for write-address handshakes under the write-transaction enable.
- R8: `evt_rd_beat` behaves in the same way for read-data beats under the read-beat enable.
- R9: While its enable bit is clear, an event output stays low, whatever the channel traffic.
- R10: A cycle with valid high and ready low, or with ready high and valid low, produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | 18 | Read address ID |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | 18 | Write address ID |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | 18 | Read data ID |
| evt_rd_txn | output | 1 | Filtered read transaction pulse |
| evt_wr_txn | output | 1 | Filtered write transaction pulse |
| evt_rd_beat | output | 1 | Filtered read beat pulse |

## Verification
The assertions assume that valid, ready and ID are stable around the clock edge. They also assume the register port is quiet during reset, so a handshake is well defined on every edge. The ID and control inputs may have any value, and X values are not allowed. The stimulus changes every input only at the falling edge. It holds all channels idle while it writes a register, then applies handshakes, half-handshakes and back-to-back beats with IDs chosen both to match and to differ under several masks.

// File: rtl/idf_pkg.sv
package idf_pkg;
  localparam int NUM_CH     = 3;
  localparam int CH_RD      = 0;
  localparam int CH_WR      = 1;
  localparam int CH_BEAT    = 2;
  localparam int EN_RD_POS  = 31;
  localparam int EN_WR_POS  = 30;
  localparam int EN_BEAT_POS = 29;
  localparam logic [3:0] CTL_OFS = 4'h0;
  localparam logic [3:0] REF_OFS = 4'h4;

  // Masked equality on 32-bit widened operands
  function automatic logic id_hit(input logic [31:0] id,
                                  input logic [31:0] ref_id,
                                  input logic [31:0] mask);
    return (id & mask) == (ref_id & mask);
  endfunction
endpackage

// File: rtl/idf_regs.sv
module idf_regs
  import idf_pkg::*;
#(
  parameter int ID_W   = 18,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [NUM_CH-1:0]   en_o,
  output logic [ID_W-1:0]     mask_o,
  output logic [ID_W-1:0]     ref_o
);
  localparam int PADW = 32 - ID_W;

  logic [NUM_CH-1:0] en_q;
  logic [ID_W-1:0]   mask_q;
  logic [ID_W-1:0]   ref_q;

  wire sel_ctl = (addr == CTL_OFS[ADDR_W-1:0]);
  wire sel_ref = (addr == REF_OFS[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      ref_q  <= '0;
    end else if (we) begin
      if (sel_ctl) begin
        en_q[CH_RD]   <= wdata[EN_RD_POS];
        en_q[CH_WR]   <= wdata[EN_WR_POS];
        en_q[CH_BEAT] <= wdata[EN_BEAT_POS];
        mask_q        <= wdata[ID_W-1:0];
      end
      if (sel_ref) begin
        ref_q <= wdata[ID_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctl) begin
      rdata[ID_W-1:0]    = mask_q;
      rdata[EN_RD_POS]   = en_q[CH_RD];
      rdata[EN_WR_POS]   = en_q[CH_WR];
      rdata[EN_BEAT_POS] = en_q[CH_BEAT];
    end else if (sel_ref) begin
      rdata = {{PADW{1'b0}}, ref_q};
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign ref_o  = ref_q;
endmodule

// File: rtl/idf_filter.sv
module idf_filter
  import idf_pkg::*;
#(
  parameter int ID_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] ref_id,
  input  logic            valid,
  input  logic            ready,
  input  logic [ID_W-1:0] id,
  output logic            hit,
  output logic            pulse
);
  localparam int PADW = 32 - ID_W;

  logic [31:0] id_w, ref_w, mask_w;
  assign id_w   = {{PADW{1'b0}}, id};
  assign ref_w  = {{PADW{1'b0}}, ref_id};
  assign mask_w = {{PADW{1'b0}}, mask};

  assign hit = valid && ready && en && id_hit(id_w, ref_w, mask_w);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= hit;
  end
endmodule

// File: rtl/idf_event_gen.sv
module idf_event_gen
  import idf_pkg::*;
#(
  parameter int ID_W   = 18,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              evt_rd_txn,
  output logic              evt_wr_txn,
  output logic              evt_rd_beat
);
  logic [NUM_CH-1:0] cfg_en;
  logic [ID_W-1:0]   cfg_mask;
  logic [ID_W-1:0]   cfg_ref;

  logic [NUM_CH-1:0] ch_valid, ch_ready, ch_hit, ch_pulse;
  logic [ID_W-1:0]   ch_id [NUM_CH];

  // Named internal events for the checker
  logic en_rd, en_wr, en_beat;
  assign en_rd   = cfg_en[CH_RD];
  assign en_wr   = cfg_en[CH_WR];
  assign en_beat = cfg_en[CH_BEAT];

  idf_regs #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .en_o   (cfg_en),
    .mask_o (cfg_mask),
    .ref_o  (cfg_ref)
  );

  assign ch_valid[CH_RD]   = ar_valid;
  assign ch_ready[CH_RD]   = ar_ready;
  assign ch_id[CH_RD]      = ar_id;
  assign ch_valid[CH_WR]   = aw_valid;
  assign ch_ready[CH_WR]   = aw_ready;
  assign ch_id[CH_WR]      = aw_id;
  assign ch_valid[CH_BEAT] = r_valid;
  assign ch_ready[CH_BEAT] = r_ready;
  assign ch_id[CH_BEAT]    = r_id;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flt
    idf_filter #(.ID_W(ID_W)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg_en[g]),
      .mask   (cfg_mask),
      .ref_id (cfg_ref),
      .valid  (ch_valid[g]),
      .ready  (ch_ready[g]),
      .id     (ch_id[g]),
      .hit    (ch_hit[g]),
      .pulse  (ch_pulse[g])
    );
  end

  assign evt_rd_txn  = ch_pulse[CH_RD];
  assign evt_wr_txn  = ch_pulse[CH_WR];
  assign evt_rd_beat = ch_pulse[CH_BEAT];
endmodule

// File: rtl/idf_event_gen_chk.sv
module idf_event_gen_chk #(
  parameter int ID_W = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     cfg_rdata,
  input logic            ar_valid,
  input logic            ar_ready,
  input logic [ID_W-1:0] ar_id,
  input logic            aw_valid,
  input logic            aw_ready,
  input logic            r_valid,
  input logic            r_ready,
  input logic            en_rd,
  input logic            en_wr,
  input logic            en_beat,
  input logic [ID_W-1:0] cfg_mask,
  input logic [ID_W-1:0] cfg_ref,
  input logic            evt_rd_txn,
  input logic            evt_wr_txn,
  input logic            evt_rd_beat
);
  localparam logic [31:0] DEF_BITS = 32'hE000_0000 | ((32'd1 << ID_W) - 32'd1);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~DEF_BITS) == 32'd0); // R4

  AST_RD_MATCH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready && en_rd && (((ar_id ^ cfg_ref) & cfg_mask) == '0))
      |=> evt_rd_txn); // R5

  AST_RD_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_txn |-> $past(ar_valid && ar_ready)); // R6

  AST_WR_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_txn |-> $past(aw_valid && aw_ready)); // R7

  AST_BEAT_NEEDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_beat |-> $past(r_valid && r_ready)); // R8

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_txn |-> $past(en_rd)) and (evt_wr_txn |-> $past(en_wr))
      and (evt_rd_beat |-> $past(en_beat))); // R9
endmodule

bind idf_event_gen idf_event_gen_chk #(.ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rdata   (cfg_rdata),
  .ar_valid    (ar_valid),
  .ar_ready    (ar_ready),
  .ar_id       (ar_id),
  .aw_valid    (aw_valid),
  .aw_ready    (aw_ready),
  .r_valid     (r_valid),
  .r_ready     (r_ready),
  .en_rd       (en_rd),
  .en_wr       (en_wr),
  .en_beat     (en_beat),
  .cfg_mask    (cfg_mask),
  .cfg_ref     (cfg_ref),
  .evt_rd_txn  (evt_rd_txn),
  .evt_wr_txn  (evt_wr_txn),
  .evt_rd_beat (evt_rd_beat)
);

// File: tb/idf_event_gen_tb.sv
`timescale 1ns/1ps
module idf_event_gen_tb;
  localparam int IDW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0, r_valid = 0, r_ready = 0;
  logic [IDW-1:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic evt_rd_txn, evt_wr_txn, evt_rd_beat;

  always #2.5 clk = ~clk;

  idf_event_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .evt_rd_txn(evt_rd_txn), .evt_wr_txn(evt_wr_txn), .evt_rd_beat(evt_rd_beat)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 0;

  // Reference model of the programmed state
  bit m_en_rd, m_en_wr, m_en_beat;
  logic [IDW-1:0] m_mask, m_ref;

  typedef struct { int stamp; logic [2:0] exp; string tag; } item_t;
  item_t sbq[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit passes(input logic [IDW-1:0] id);
    return ((id ^ m_ref) & m_mask) == '0;
  endfunction

  // Monitor: pop items whose driving cycle has been clocked
  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] got, exp;
      string tag;
      got = {evt_rd_beat, evt_wr_txn, evt_rd_txn};
      if (sbq.size() > 0 && sbq[0].stamp < cyc) begin
        exp = sbq[0].exp; tag = sbq[0].tag;
        void'(sbq.pop_front());
      end else begin
        exp = 3'b000; tag = "R9/R10 idle";
      end
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s: events {beat,wr,rd} actual %b expected %b at cycle %0d", tag, got, exp, cyc);
      end
    end
  end

  task automatic drive(input bit av, input bit ar, input logic [IDW-1:0] aid,
                       input bit wv, input bit wr, input logic [IDW-1:0] wid,
                       input bit rv, input bit rr, input logic [IDW-1:0] rid,
                       input string tag);
    item_t it;
    @(negedge clk);
    ar_valid = av; ar_ready = ar; ar_id = aid;
    aw_valid = wv; aw_ready = wr; aw_id = wid;
    r_valid = rv; r_ready = rr; r_id = rid;
    it.stamp = cyc;
    it.tag = tag;
    it.exp[0] = av && ar && m_en_rd && passes(aid);
    it.exp[1] = wv && wr && m_en_wr && passes(wid);
    it.exp[2] = rv && rr && m_en_beat && passes(rid);
    sbq.push_back(it);
  endtask

  task automatic idle_ch();
    @(negedge clk);
    ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0; r_valid = 0; r_ready = 0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    idle_ch();
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    if (a == 4'h0) begin
      m_en_rd = d[31]; m_en_wr = d[30]; m_en_beat = d[29]; m_mask = d[17:0];
    end else if (a == 4'h4) begin
      m_ref = d[17:0];
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_we = 0; cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: offset %h actual %h expected %h", tag, a, cfg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_en_rd = 0; m_en_wr = 0; m_en_beat = 0; m_mask = '0; m_ref = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd_chk(4'h0, 32'h0, "R1 ctl after reset");
    rd_chk(4'h4, 32'h0, "R1 ref after reset");
    mon_on = 1;
    // R1 events low, R9 all disabled: traffic gives no pulse
    drive(1,1,18'h1,1,1,18'h2,1,1,18'h3,"R9 disabled at reset");
    idle_ch();

    // R2/R3/R4: field readback, reserved bits dropped
    wr_reg(4'h0, 32'hFFFF_FFFF);
    rd_chk(4'h0, 32'hE003_FFFF, "R2 R4 ctl all ones");
    wr_reg(4'h4, 32'hFFFF_FFFF);
    rd_chk(4'h4, 32'h0003_FFFF, "R3 R4 ref all ones");
    wr_reg(4'h0, 32'hA001_2345);
    rd_chk(4'h0, 32'hA001_2345, "R2 ctl pattern");
    wr_reg(4'h8, 32'hFFFF_FFFF);
    rd_chk(4'h8, 32'h0, "R4 unmapped reads zero");
    rd_chk(4'h0, 32'hA001_2345, "R4 unmapped write leaves ctl");
    rd_chk(4'h4, 32'h0003_FFFF, "R4 unmapped write leaves ref");

    // R5: zero mask matches any ID
    wr_reg(4'h0, 32'hE000_0000);
    wr_reg(4'h4, 32'h0001_2345);
    for (int i = 0; i < 8; i++)
      drive(1,1,18'($urandom),1,1,18'($urandom),1,1,18'($urandom),"R5 zero mask");
    idle_ch();

    // R5-R8: masked match, hits and misses
    wr_reg(4'h0, 32'hE003_F00F);
    drive(1,1,18'h12345,1,1,18'h12AB5,1,1,18'h02345,"R5 R6 R7 R8 masked");
    drive(1,1,18'h12346,1,1,18'h12FF5,1,1,18'h12005,"R5 R6 R7 R8 masked");
    for (int i = 0; i < 20; i++)
      drive(1,1,18'($urandom),1,1,18'($urandom),1,1,18'($urandom),"R5 random ids");

    // R6-R8: back-to-back matching handshakes
    for (int i = 0; i < 4; i++)
      drive(1,1,18'h12345,1,1,18'h12345,1,1,18'h12345,"R6 R7 R8 back-to-back");
    idle_ch();

    // R10: half handshakes
    drive(1,0,18'h12345,0,1,18'h12345,1,0,18'h12345,"R10 half handshake");
    drive(0,1,18'h12345,1,0,18'h12345,0,1,18'h12345,"R10 half handshake");
    idle_ch();

    // R9: each enable alone
    wr_reg(4'h0, 32'h8000_0000);
    drive(1,1,18'h1,1,1,18'h1,1,1,18'h1,"R9 only rd enabled");
    wr_reg(4'h0, 32'h4000_0000);
    drive(1,1,18'h1,1,1,18'h1,1,1,18'h1,"R9 only wr enabled");
    wr_reg(4'h0, 32'h2000_0000);
    drive(1,1,18'h1,1,1,18'h1,1,1,18'h1,"R9 only beat enabled");
    wr_reg(4'h0, 32'h0000_0000);
    drive(1,1,18'h1,1,1,18'h1,1,1,18'h1,"R9 all disabled");
    idle_ch();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule